// File: doc/BRIEF.md
# Load/Store Address and Access Sequencer

This block runs the data-movement instructions of a 16-bit processor with a 16-bit word-addressed space. Each accepted instruction first gets an effective address. For most opcodes this is the already-incremented program counter plus a 9-bit offset. For the base form it is a register value plus a 6-bit offset. The block then performs zero, one or two accesses on a single-port memory port that uses request and ready signals.

Loads and the address-only instruction finish with a writeback of a word, a destination index and a fresh N/Z/P flag value. Stores finish with no writeback and no flag update. The pointer forms read a pointer word from memory first, then use it as the address of the data access.

The surrounding pipeline supplies the instruction and the values read from its register file: the incremented PC, the base register value and the store source value. It raises `start` for one cycle and waits for `done`. While the block is busy it ignores `start`. It also ignores `start` when the opcode is not one it handles.

Top module: `ldst_sequencer`

## Requirements
- R1: After reset, `memReq`, `done`, `wbEn` and `flagsEn` are low, and they stay low until an accepted start.
- R2: Opcodes 0010 (load), 1010 (pointer load), 0011 (store), 1011 (pointer store) and 1110 (address-only) use the address `pcNext` plus `instr[8:0]` sign-extended to 16 bits, modulo 2^16.
- R3: Opcodes 0110 (base load) and 0111 (base store) use the address `baseVal` plus `instr[5:0]` sign-extended to 16 bits, modulo 2^16.
- R4: The pointer opcodes make two accesses in order. The first is a read at the computed address. The second is at the word returned by that read: a read for 1010, a write for 1011.
- R5: Loads end with `done`, `wbEn` high, `wbIdx` = `instr[11:9]` and `wbData` = the word returned by the final read.
- R6: The address-only opcode makes no memory request. It raises `done` in the cycle after the start, with `wbEn` high and `wbData` equal to the computed address.
- R7: Stores write `srcVal` (the value at start) with `memWe` high, and end with `done` while `wbEn` and `flagsEn` stay low.
- R8: With `flagsEn`, `flags` is one-hot: bit 2 N (`wbData` negative), bit 1 Z (zero), bit 0 P (positive). `flagsEn` is high exactly when `wbEn` is high.
- R9: A request holds `memAddr`, `memWe` and `memWdata` stable until a cycle with `memReady` high. That cycle completes the access.
- R10: `start` is ignored while an instruction is in progress, and also for any opcode outside the seven listed.
- R11: `done` rises in the cycle after the last access completes and lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin the instruction on `instr` |
| instr | input | 16 | Instruction word |
| pcNext | input | 16 | Incremented program counter |
| baseVal | input | 16 | Base register value |
| srcVal | input | 16 | Store source register value |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Write enable for the request |
| memAddr | output | 16 | Word address |
| memWdata | output | 16 | Write data |
| memRdata | input | 16 | Read data, valid with `memReady` |
| memReady | input | 1 | Completes the pending request |
| done | output | 1 | Instruction complete (one cycle) |
| wbEn | output | 1 | Register writeback valid |
| wbIdx | output | 3 | Destination register index |
| wbData | output | 16 | Writeback value |
| flagsEn | output | 1 | Flag update valid |
| flags | output | 3 | {N, Z, P} |

## Verification
The bench sweeps every handled opcode across offsets at the extremes of their sign-extended range and across PC and base values that wrap past 0xFFFF. A design that sign-extends wrongly, picks the wrong offset field or drops the carry would show up as a wrong first access address. The memory model answers after zero, one or two wait cycles. An access that moves its address while waiting, or finishes before ready, fails the hold checks. The pointer forms are checked for the order and address of both accesses. A design that writes at the pointer's own address, or reuses the first address, is caught there. The bench also targets three more faults: results that land on zero or on negative words, which catch a wrong flag encoding; a start raised mid-access or with a foreign opcode, which a design that restarts would answer with a spurious request; and a store that writes back or updates flags.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
  localparam int INSTR_W = 16;
  localparam int OPC_W   = 4;

  typedef enum logic [OPC_W-1:0] {
    OPC_LOAD   = 4'b0010,
    OPC_LOADP  = 4'b1010,
    OPC_LOADB  = 4'b0110,
    OPC_ADDR   = 4'b1110,
    OPC_STORE  = 4'b0011,
    OPC_STOREP = 4'b1011,
    OPC_STOREB = 4'b0111
  } opcode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PTR,
    ST_DATA,
    ST_FIN
  } seqState_e;

  typedef struct packed {
    logic capture;
    logic useBase;
    logic ptrToAddr;
    logic rdToResult;
  } ctrlStrobes_t;
endpackage

// File: rtl/ldst_ctrl.sv
module ldst_ctrl
  import ldst_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [OPC_W-1:0]   opcode,
  input  logic               memReady,
  output ctrlStrobes_t       strobes,
  output logic               memReq,
  output logic               memWe,
  output logic               done,
  output logic               wbEn,
  output logic               flagsEn
);
  seqState_e state, stateNxt;
  logic storeQ, leaQ;
  logic legal, isBase, isPtr, isStore, isLea;

  always_comb begin
    legal = 1'b1; isBase = 1'b0; isPtr = 1'b0; isStore = 1'b0; isLea = 1'b0;
    case (opcode)
      OPC_LOAD:   ;
      OPC_LOADP:  isPtr = 1'b1;
      OPC_LOADB:  isBase = 1'b1;
      OPC_ADDR:   isLea = 1'b1;
      OPC_STORE:  isStore = 1'b1;
      OPC_STOREP: begin isStore = 1'b1; isPtr = 1'b1; end
      OPC_STOREB: begin isStore = 1'b1; isBase = 1'b1; end
      default:    legal = 1'b0;
    endcase
  end

  logic accept;
  assign accept = start && (state == ST_IDLE) && legal;

  always_comb begin
    stateNxt = state;
    case (state)
      ST_IDLE: if (accept) stateNxt = isLea ? ST_FIN : (isPtr ? ST_PTR : ST_DATA);
      ST_PTR:  if (memReady) stateNxt = ST_DATA;
      ST_DATA: if (memReady) stateNxt = ST_FIN;
      ST_FIN:  stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      storeQ <= 1'b0;
      leaQ   <= 1'b0;
    end else begin
      state <= stateNxt;
      if (accept) begin
        storeQ <= isStore;
        leaQ   <= isLea;
      end
    end
  end

  always_comb begin
    strobes.capture    = accept;
    strobes.useBase    = isBase;
    strobes.ptrToAddr  = (state == ST_PTR) && memReady;
    strobes.rdToResult = (state == ST_DATA) && memReady && !storeQ;
  end

  assign memReq  = (state == ST_PTR) || (state == ST_DATA);
  assign memWe   = (state == ST_DATA) && storeQ;
  assign done    = (state == ST_FIN);
  assign wbEn    = done && (!storeQ || leaQ);
  assign flagsEn = wbEn;
endmodule

// File: rtl/ldst_dp.sv
module ldst_dp
  import ldst_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int IDX_W      = 3,
  parameter int PC_OFF_W   = 9,
  parameter int BASE_OFF_W = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [INSTR_W-1:0] instr,
  input  logic [DATA_W-1:0]  pcNext,
  input  logic [DATA_W-1:0]  baseVal,
  input  logic [DATA_W-1:0]  srcVal,
  input  logic [DATA_W-1:0]  memRdata,
  output logic [DATA_W-1:0]  memAddr,
  output logic [DATA_W-1:0]  memWdata,
  output logic [IDX_W-1:0]   wbIdx,
  output logic [DATA_W-1:0]  wbData,
  output logic [2:0]         flags
);
  localparam int DST_LSB = INSTR_W - OPC_W - IDX_W;

  logic [DATA_W-1:0] pcOff, baseOff, effAddr;
  logic [DATA_W-1:0] addrQ, resultQ, srcQ;
  logic [IDX_W-1:0]  dstQ;

  assign pcOff   = {{(DATA_W-PC_OFF_W){instr[PC_OFF_W-1]}}, instr[PC_OFF_W-1:0]};
  assign baseOff = {{(DATA_W-BASE_OFF_W){instr[BASE_OFF_W-1]}}, instr[BASE_OFF_W-1:0]};
  assign effAddr = strobes.useBase ? (baseVal + baseOff) : (pcNext + pcOff);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      resultQ <= '0;
      srcQ    <= '0;
      dstQ    <= '0;
    end else begin
      if (strobes.capture) begin
        addrQ   <= effAddr;
        resultQ <= effAddr;
        srcQ    <= srcVal;
        dstQ    <= instr[DST_LSB +: IDX_W];
      end
      if (strobes.ptrToAddr)  addrQ   <= memRdata;
      if (strobes.rdToResult) resultQ <= memRdata;
    end
  end

  assign memAddr  = addrQ;
  assign memWdata = srcQ;
  assign wbIdx    = dstQ;
  assign wbData   = resultQ;

  always_comb begin
    flags[2] = resultQ[DATA_W-1];
    flags[1] = (resultQ == '0);
    flags[0] = !resultQ[DATA_W-1] && (resultQ != '0);
  end
endmodule

// File: rtl/ldst_sequencer.sv
module ldst_sequencer
  import ldst_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [INSTR_W-1:0] instr,
  input  logic [DATA_W-1:0]  pcNext,
  input  logic [DATA_W-1:0]  baseVal,
  input  logic [DATA_W-1:0]  srcVal,
  output logic               memReq,
  output logic               memWe,
  output logic [DATA_W-1:0]  memAddr,
  output logic [DATA_W-1:0]  memWdata,
  input  logic [DATA_W-1:0]  memRdata,
  input  logic               memReady,
  output logic               done,
  output logic               wbEn,
  output logic [IDX_W-1:0]   wbIdx,
  output logic [DATA_W-1:0]  wbData,
  output logic               flagsEn,
  output logic [2:0]         flags
);
  ctrlStrobes_t strobes;

  ldst_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .start(start),
    .opcode(instr[INSTR_W-1 -: OPC_W]), .memReady(memReady),
    .strobes(strobes), .memReq(memReq), .memWe(memWe),
    .done(done), .wbEn(wbEn), .flagsEn(flagsEn)
  );

  ldst_dp #(.DATA_W(DATA_W), .IDX_W(IDX_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .instr(instr),
    .pcNext(pcNext), .baseVal(baseVal), .srcVal(srcVal),
    .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata),
    .wbIdx(wbIdx), .wbData(wbData), .flags(flags)
  );
endmodule

// File: rtl/ldst_sequencer_chk.sv
module ldst_sequencer_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic              memWe,
  input logic [DATA_W-1:0] memAddr,
  input logic [DATA_W-1:0] memWdata,
  input logic              memReady,
  input logic              done,
  input logic              wbEn,
  input logic              flagsEn,
  input logic [2:0]        flags
);
  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memReady |=> memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata));

  // R8
  flags_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagsEn |-> $countones(flags) == 1);

  // R8
  flags_wb_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagsEn == wbEn);

  // R7
  store_nowb_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe && memReady |=> done && !wbEn);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R5
  wb_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |-> done);

  // R10
  no_req_at_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !memReq);
endmodule

bind ldst_sequencer ldst_sequencer_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
  .memWdata(memWdata), .memReady(memReady), .done(done), .wbEn(wbEn),
  .flagsEn(flagsEn), .flags(flags)
);

// File: tb/ldst_sequencer_tb.sv
module ldst_sequencer_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] instr = '0, pcNext = '0, baseVal = '0, srcVal = '0;
  logic        memReq, memWe, memReady = 1'b0;
  logic [15:0] memAddr, memWdata, memRdata = '0;
  logic        done, wbEn, flagsEn;
  logic [2:0]  wbIdx, flags;
  logic [15:0] wbData;

  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  ldst_sequencer dut_i (
    .clk(clk), .rstN(rstN), .start(start), .instr(instr), .pcNext(pcNext),
    .baseVal(baseVal), .srcVal(srcVal), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .memReady(memReady), .done(done), .wbEn(wbEn), .wbIdx(wbIdx),
    .wbData(wbData), .flagsEn(flagsEn), .flags(flags)
  );

  function automatic logic [15:0] memModel(input logic [15:0] a);
    return a + 16'h3000;
  endfunction

  function automatic logic [2:0] expFlags(input logic [15:0] v);
    if (v[15]) return 3'b100;
    if (v == 16'h0) return 3'b010;
    return 3'b001;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic runInstr(input logic [15:0] ins, input logic [15:0] pc, input logic [15:0] base,
                          input logic [15:0] src, input int waitN, input bit poke);
    logic [3:0]  opc;
    logic [15:0] ea, a1, expRes;
    logic [15:0] aAddr[2], aWd[2];
    bit          aWe[2];
    int          expAcc, accN, w;
    bit          isStore, pend, poked, seenDone;
    logic [15:0] lastA, lastWd;
    logic        lastWe;
    string       addrTag;
    opc = ins[15:12];
    isStore = (opc == 4'b0011) || (opc == 4'b1011) || (opc == 4'b0111);
    if (opc == 4'b0110 || opc == 4'b0111) begin
      ea = base + {{10{ins[5]}}, ins[5:0]}; addrTag = "R3";
    end else begin
      ea = pc + {{7{ins[8]}}, ins[8:0]}; addrTag = "R2";
    end
    a1 = memModel(ea);
    expAcc = (opc == 4'b1110) ? 0 : ((opc == 4'b1010 || opc == 4'b1011) ? 2 : 1);
    expRes = (opc == 4'b1110) ? ea : ((expAcc == 2) ? memModel(a1) : memModel(ea));

    @(negedge clk);
    start = 1'b1; instr = ins; pcNext = pc; baseVal = base; srcVal = src;
    @(negedge clk);
    start = 1'b0; instr = 16'h2000 ^ ~ins; pcNext = ~pc; baseVal = ~base; srcVal = ~src;
    accN = 0; w = 0; pend = 0; poked = 0; seenDone = 0;
    lastA = '0; lastWd = '0; lastWe = 1'b0;
    for (int c = 0; c < 40; c++) begin
      if (c > 0) @(negedge clk);
      if (poked) start = 1'b0;
      if (memReady) begin memReady = 1'b0; w = 0; end
      if (done) begin seenDone = 1; break; end
      if (memReq) begin
        if (pend) begin
          check(memAddr == lastA && memWe == lastWe && memWdata == lastWd, "R9", memAddr, lastA);
        end
        if (poke && !poked && accN == 0) begin
          start = 1'b1; instr = 16'h21F0; poked = 1;
        end
        pend = 1; lastA = memAddr; lastWe = memWe; lastWd = memWdata;
        if (w == waitN) begin
          if (accN < 2) begin aAddr[accN] = memAddr; aWe[accN] = memWe; aWd[accN] = memWdata; end
          accN++;
          memRdata = memModel(memAddr);
          memReady = 1'b1;
          pend = 0;
        end else begin
          w++;
        end
      end
    end
    start = 1'b0;
    check(seenDone, "R11", seenDone, 1);
    check(accN == expAcc, (expAcc == 0) ? "R6" : "R4", accN, expAcc);
    if (accN >= 1 && expAcc >= 1) begin
      check(aAddr[0] == ea, addrTag, aAddr[0], ea);
      if (expAcc == 1) begin
        check(aWe[0] == isStore, "R7", aWe[0], isStore);
        if (isStore) check(aWd[0] == src, "R7", aWd[0], src);
      end else begin
        check(aWe[0] == 1'b0, "R4", aWe[0], 0);
      end
    end
    if (accN == 2 && expAcc == 2) begin
      check(aAddr[1] == a1, "R4", aAddr[1], a1);
      check(aWe[1] == isStore, "R4", aWe[1], isStore);
      if (isStore) check(aWd[1] == src, "R7", aWd[1], src);
    end
    if (seenDone) begin
      if (isStore) begin
        check(!wbEn && !flagsEn, "R7", {wbEn, flagsEn}, 0);
      end else begin
        check(wbEn, (opc == 4'b1110) ? "R6" : "R5", wbEn, 1);
        check(wbData == expRes, (opc == 4'b1110) ? "R6" : "R5", wbData, expRes);
        check(wbIdx == ins[11:9], "R5", wbIdx, ins[11:9]);
        check(flagsEn && flags == expFlags(expRes), "R8", {flagsEn, flags}, {1'b1, expFlags(expRes)});
      end
      @(negedge clk);
      check(!done, "R11", done, 0);
    end
  endtask

  initial begin
    #1_000_000;
    fails++; total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [3:0]  opcs[7];
    logic [8:0]  off9[4];
    logic [5:0]  off6[4];
    logic [15:0] pcs[4], bases[4];
    opcs  = '{4'b0010, 4'b1010, 4'b0110, 4'b1110, 4'b0011, 4'b1011, 4'b0111};
    off9  = '{9'h0FF, 9'h100, 9'h000, 9'h1FF};
    off6  = '{6'h1F, 6'h20, 6'h00, 6'h3F};
    pcs   = '{16'h0010, 16'hFFF0, 16'h6000, 16'hD000};
    bases = '{16'h7FF0, 16'h0005, 16'hC000, 16'h4FC1};

    repeat (3) @(negedge clk);
    // R1 reset state
    check(!memReq && !done && !wbEn && !flagsEn, "R1", {memReq, done, wbEn, flagsEn}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(!memReq && !done && !wbEn && !flagsEn, "R1", {memReq, done, wbEn, flagsEn}, 0);

    for (int o = 0; o < 7; o++)
      for (int k = 0; k < 4; k++)
        for (int wt = 0; wt < 3; wt++) begin
          logic [15:0] ins;
          if (opcs[o] == 4'b0110 || opcs[o] == 4'b0111)
            ins = {opcs[o], 3'(o + k), 3'(k), off6[k]};
          else
            ins = {opcs[o], 3'(o + k), off9[k]};
          runInstr(ins, pcs[k], bases[k], 16'hA50F ^ 16'(k * 257), wt, 1'b0);
        end

    // zero-valued load and zero address-only result (R8)
    runInstr({4'b0010, 3'd1, 9'h000}, 16'hD000, 16'h0, 16'h0, 0, 1'b0);
    runInstr({4'b1110, 3'd2, 9'h000}, 16'h0000, 16'h0, 16'h0, 1, 1'b0);

    // R10 start raised mid-access is ignored
    runInstr({4'b1010, 3'd5, 9'h010}, 16'h1000, 16'h0, 16'h0, 2, 1'b1);
    runInstr({4'b0111, 3'd6, 3'd0, 6'h21}, 16'h0, 16'h8000, 16'h1234, 1, 1'b1);

    // R10 foreign opcodes are ignored
    for (int f = 0; f < 3; f++) begin
      logic [3:0] bad;
      bit sawReq;
      bad = (f == 0) ? 4'b0001 : ((f == 1) ? 4'b1100 : 4'b1111);
      @(negedge clk);
      start = 1'b1; instr = {bad, 12'h0F3};
      @(negedge clk);
      start = 1'b0;
      sawReq = 0;
      for (int c = 0; c < 5; c++) begin
        if (memReq || done || wbEn) sawReq = 1;
        @(negedge clk);
      end
      check(!sawReq, "R10", sawReq, 0);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule